// File: doc/BRIEF.md
# Floating-Point Ordering Comparator

This block takes two packed binary floating-point words and reports how they order: less-than, equal, greater-than or unordered. It does not split each operand into sign, exponent and significand and compare those parts in turn. Instead, it makes a single unsigned comparison of the magnitude bits, which are every bit except the sign. This works because a biased exponent placed above the significand makes the integer order of those bits match the order of the magnitudes. A small amount of fix-up logic then handles the cases this comparison gets wrong: operands of opposite sign, two negative operands, the two encodings of zero, and NaN inputs.

The default format is single precision: 1 sign bit, 8 exponent bits and 23 significand bits. The exponent and significand widths are parameters, so the same logic can be built for narrower formats.

Operand pairs enter on a valid/ready stream, and the flags leave one cycle later on a second valid/ready stream, held in one register stage. The upstream side may only present a pair, or change it, as the handshake allows. A pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new pair is accepted.

Top module: `fcmp_top`

## Requirements
- R1: The word layout is: the sign in the top bit (1 means negative), then an EXP_W-bit biased exponent, then an MAN_W-bit significand in the low bits. Whenever `out_valid` is high, exactly one of `lt`, `eq`, `gt` and `un` is set.
- R2: If either operand has an all-ones exponent and a nonzero significand (NaN), the result is `un`=1 with `lt`, `eq` and `gt` all 0.
- R3: +0 and -0 (every bit except the sign is zero) compare equal in all four sign combinations.
- R4: For two positive, non-NaN operands, the one with the larger magnitude is the greater. Subnormal operands are included.
- R5: For two negative, non-NaN operands, the one with the larger magnitude is the lesser.
- R6: When the signs differ and the operands are not both zero, the negative operand is the lesser.
- R7: Two identical non-NaN encodings give `eq`.
- R8: Infinity (all-ones exponent, zero significand) orders above every finite value when positive and below every finite value when negative. Two infinities of the same sign compare equal.
- R9: A pair accepted on one clock edge shows its flags with `out_valid` high after the next edge. With `in_valid` low and `out_ready` high, `out_valid` falls after one edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the flags and `out_valid` hold. While `out_valid` is low, `in_ready` is high.
- R11: During and after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | Flags present |
| out_ready | input | 1 | Downstream takes the flags |
| lt | output | 1 | op_a orders below op_b |
| eq | output | 1 | Operands compare equal |
| gt | output | 1 | op_a orders above op_b |
| un | output | 1 | Unordered, at least one NaN |

## Verification
Four properties are checked on every cycle: a valid result carries exactly one flag; any NaN operand yields unordered; a pair of zeros yields equal; and the handshake keeps its one-cycle latency and holds its result under back-pressure. The ordering itself is shown only by the bench. It sweeps every pair of operands in a 6-bit format, which covers subnormals, infinities, both zero encodings and every sign mix, and compares each result against the real values the bench decodes on its own. A stall scenario shows that a result is held, and that a second pair waits, until the downstream side takes the first result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } fcmp_flags_t;
endpackage

// File: rtl/fcmp_classify.sv
// Spots NaN and zero from the magnitude bits of one operand.
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W-1:0] mag,
  output logic             is_nan,
  output logic             is_zero
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  assign expo    = mag[MAG_W-1 -: EXP_W];
  assign frac    = mag[MAN_W-1:0];
  assign is_nan  = (&expo) && (|frac);
  assign is_zero = ~|mag;
endmodule

// File: rtl/fcmp_order.sv
// One unsigned magnitude compare, corrected for sign, zero and NaN.
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          a_nan,
  input  logic          b_nan,
  input  logic          a_zero,
  input  logic          b_zero,
  output fcmp_flags_t   flags
);
  logic mag_lt;
  logic mag_eq;
  logic sa;
  logic sb;

  assign mag_lt = a[W-2:0] < b[W-2:0];
  assign mag_eq = a[W-2:0] == b[W-2:0];
  assign sa     = a[W-1];
  assign sb     = b[W-1];

  always_comb begin
    flags = '0;
    if (a_nan || b_nan) begin
      flags.un = 1'b1;
    end else if (a_zero && b_zero) begin
      flags.eq = 1'b1;
    end else if (sa != sb) begin
      flags.lt = sa;
      flags.gt = sb;
    end else if (mag_eq) begin
      flags.eq = 1'b1;
    end else if (sa) begin
      flags.lt = ~mag_lt;
      flags.gt = mag_lt;
    end else begin
      flags.lt = mag_lt;
      flags.gt = ~mag_lt;
    end
  end
endmodule

// File: rtl/fcmp_stage.sv
// Single result register with valid/ready on both sides.
module fcmp_stage
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  fcmp_flags_t d,
  output logic        out_valid,
  input  logic        out_ready,
  output fcmp_flags_t q
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fcmp_top.sv
module fcmp_top
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         lt,
  output logic         eq,
  output logic         gt,
  output logic         un
);
  logic [W-1:0] ops [2];
  logic [1:0]   nan_v;
  logic [1:0]   zero_v;
  fcmp_flags_t  comb_flags;
  fcmp_flags_t  reg_flags;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .mag     (ops[i][W-2:0]),
      .is_nan  (nan_v[i]),
      .is_zero (zero_v[i])
    );
  end

  fcmp_order #(.W(W)) u_order (
    .a      (op_a),
    .b      (op_b),
    .a_nan  (nan_v[0]),
    .b_nan  (nan_v[1]),
    .a_zero (zero_v[0]),
    .b_zero (zero_v[1]),
    .flags  (comb_flags)
  );

  fcmp_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (comb_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (reg_flags)
  );

  assign lt = reg_flags.lt;
  assign eq = reg_flags.eq;
  assign gt = reg_flags.gt;
  assign un = reg_flags.un;
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic         lt,
  input logic         eq,
  input logic         gt,
  input logic         un
);
  logic take;
  logic any_nan;
  logic both_zero;

  assign take      = in_valid && in_ready;
  assign any_nan   = ((&op_a[W-2 -: EXP_W]) && (|op_a[MAN_W-1:0])) ||
                     ((&op_b[W-2 -: EXP_W]) && (|op_b[MAN_W-1:0]));
  assign both_zero = (op_a[W-2:0] == '0) && (op_b[W-2:0] == '0);

  assert_one_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({lt, eq, gt, un}) == 1);

  assert_nan_unordered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && any_nan) |=> (un && !lt && !eq && !gt));

  assert_zero_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && both_zero) |=> (eq && !un));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({lt, eq, gt, un})));

  assert_ready_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind fcmp_top fcmp_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fcmp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .lt        (lt),
  .eq        (eq),
  .gt        (gt),
  .un        (un)
);

// File: tb/test_fcmp_top.sv
`timescale 1ns/1ps
module test_fcmp_top;
  localparam int EXP_W = 3;
  localparam int MAN_W = 2;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         lt, eq, gt, un;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fcmp_top #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_fcmp_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .lt(lt), .eq(eq), .gt(gt), .un(un)
  );

  function automatic bit is_nan(logic [W-1:0] x);
    return (x[W-2 -: EXP_W] == '1) && (x[MAN_W-1:0] != '0);
  endfunction

  function automatic bit is_inf(logic [W-1:0] x);
    return (x[W-2 -: EXP_W] == '1) && (x[MAN_W-1:0] == '0);
  endfunction

  // Real value of a word; infinity stands in as a huge number.
  function automatic real decode(logic [W-1:0] x);
    int  e;
    real f;
    real v;
    e = int'(x[W-2 -: EXP_W]);
    f = real'(int'(x[MAN_W-1:0])) / real'(1 << MAN_W);
    if (is_inf(x))   v = 1.0e9;
    else if (e == 0) v = f * (2.0 ** (1 - BIAS));
    else             v = (1.0 + f) * (2.0 ** (e - BIAS));
    return x[W-1] ? -v : v;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %b expected %b (a=%b b=%b)", tag, got, want, op_a, op_b);
    end
  endtask

  function automatic string tag_of(logic [W-1:0] a, logic [W-1:0] b);
    if (is_nan(a) || is_nan(b))                 return "R2";
    if (a[W-2:0] == '0 && b[W-2:0] == '0)        return "R3";
    if (is_inf(a) || is_inf(b))                 return "R8";
    if (a == b)                                 return "R7";
    if (a[W-1] != b[W-1])                       return "R6";
    if (a[W-1])                                 return "R5";
    return "R4";
  endfunction

  function automatic logic [3:0] expect_flags(logic [W-1:0] a, logic [W-1:0] b);
    real va;
    real vb;
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    va = decode(a);
    vb = decode(b);
    if (va < vb) return 4'b1000;
    if (va > vb) return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    op_a     = a;
    op_b     = b;
    in_valid = 1'b1;
    @(negedge clk);
    check("R9 out_valid", {3'b000, out_valid}, 4'b0001);
    check(tag_of(a, b), {lt, eq, gt, un}, expect_flags(a, b));
    check("R1 one flag", 4'($countones({lt, eq, gt, un})), 4'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {3'b000, out_valid}, 4'b0000);
    check("R11 in_ready in reset", {3'b000, in_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid after reset", {3'b000, out_valid}, 4'b0000);

    // Full sweep of every operand pair.
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        apply(W'(i), W'(j));

    // R9: out_valid falls once input stops and output drains.
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 drain", {3'b000, out_valid}, 4'b0000);

    // R10: stall holds result and blocks a second pair.
    out_ready = 1'b0;
    op_a = 6'b0_011_00;  // +1.0
    op_b = 6'b0_100_00;  // +2.0
    in_valid = 1'b1;
    @(negedge clk);
    op_a = 6'b0_100_00;
    op_b = 6'b0_011_00;
    check("R10 in_ready low on stall", {3'b000, in_ready}, 4'b0000);
    @(negedge clk);
    @(negedge clk);
    check("R10 held flags", {lt, eq, gt, un}, 4'b1000);
    check("R10 held valid", {3'b000, out_valid}, 4'b0001);
    out_ready = 1'b1;
    #0.1;
    check("R10 ready on drain", {3'b000, in_ready}, 4'b0001);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second pair", {lt, eq, gt, un}, 4'b0010);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule